// File: doc/BRIEF.md
# CAN Receive Message Store

This block is the two-stage message store on the receive side of a CAN controller. The bit-level receiver writes each incoming frame one byte at a time into a background buffer. Only the controller can reach that buffer. When the receiver reports that a frame ended correctly, the block decides whether to pass it on. It looks at the identifier-filter verdict, at whether the frame was the controller's own transmission, and at the loop-back setting. A frame that qualifies is copied as a whole into a foreground buffer. The CPU reads the foreground buffer byte by byte through one address window.

A receiver-full flag guards the foreground copy. It stays set until the CPU writes a one to clear it. A frame that qualifies while the flag is set stays pending in the background buffer. It moves to the foreground one cycle after the CPU releases the flag. A further qualifying frame that completes while a frame is pending is dropped, and a sticky overrun flag records the loss. The receive interrupt is the receiver-full flag gated by an enable bit.

Top module: `canRxStore`

## Requirements
- R1: After reset, `rxFull`, `rxOvr` and `rxIrq` are all 0.
- R2: The foreground buffer holds 13 bytes, read at `cpuRdAddr` 0 to 12 with the data combinationally on `cpuRdData`. Addresses 13 to 15 read as 0.
- R3: A frame qualifies when `rxDone` is high together with `rxAccept`, and either `rxOwn` is low or `loopBack` is high. If a frame qualifies while `rxFull` is 0 and no frame is pending, the clock edge that samples `rxDone` copies all 13 background bytes into the foreground and sets `rxFull`.
- R4: `rxIrq` is high exactly when `rxFull` is 1 and `rxIntEn` is 1.
- R5: A completed frame with `rxAccept` low leaves the foreground contents and `rxFull` unchanged.
- R6: A completed frame with `rxOwn` high and `loopBack` low is never copied and does not set `rxFull`. With `loopBack` high the same frame is copied like any other.
- R7: A frame that qualifies while `rxFull` is 1 becomes pending. `rxFull` clears on the edge that samples `cpuClrFull`. On the next edge the pending frame is copied and `rxFull` is set again.
- R8: While a frame is pending, background writes are ignored. A further qualifying frame completing then sets `rxOvr` and is discarded, and the pending frame reaches the foreground intact.
- R9: `rxFull` and `rxOvr` are sticky. Each one clears only on a one-cycle pulse of its own clear input (`cpuClrFull`, `cpuClrOvr`).
- R10: Background writes go ahead while the foreground is full and nothing is pending, so a new frame can be received before the CPU releases the foreground.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxWrEn | input | 1 | Background byte write strobe |
| rxWrAddr | input | 4 | Background byte index |
| rxWrData | input | 8 | Background byte value |
| rxDone | input | 1 | Frame completed correctly (one-cycle pulse) |
| rxAccept | input | 1 | Identifier filter verdict, valid with rxDone |
| rxOwn | input | 1 | Frame was own transmission (low if arbitration was lost), valid with rxDone |
| loopBack | input | 1 | Loop-back mode: own frames are treated as foreign ones |
| rxIntEn | input | 1 | Receive interrupt enable |
| cpuRdAddr | input | 4 | Foreground byte index |
| cpuRdData | output | 8 | Foreground byte value |
| cpuClrFull | input | 1 | Write-one-to-clear of the receiver-full flag |
| cpuClrOvr | input | 1 | Write-one-to-clear of the overrun flag |
| rxFull | output | 1 | Receiver-full flag |
| rxOvr | output | 1 | Overrun flag |
| rxIrq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is a full foreground, a pending background frame and a third frame all at once. To get there, the stimulus holds the foreground unreleased and streams a second frame, which becomes pending. It then writes a third frame with different byte values, so that any leak of its bytes into the pending frame shows up. After the CPU releases the foreground, the bench checks the one-cycle gap in `rxFull` and then the whole foreground contents. Before that, a sweep over every combination of filter verdict, own-frame flag, loop-back setting and interrupt enable checks the copy decision and the interrupt gate, each with a distinct byte pattern.

// File: rtl/canRxPkg.sv
package canRxPkg;
  localparam int MSG_BYTES = 13;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = $clog2(MSG_BYTES);

  typedef struct packed {
    logic bgWrite;   // store the incoming byte in the background buffer
    logic copyToFg;  // move the whole background frame to the foreground
  } bufCmd_t;
endpackage

// File: rtl/canRxBufDp.sv
module canRxBufDp
  import canRxPkg::*;
#(
  parameter int NBYTES = MSG_BYTES,
  parameter int DW     = BYTE_W,
  parameter int AW     = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  bufCmd_t       cmd,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] bgMem [NBYTES];
  logic [DW-1:0] fgMem [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bgMem[i] <= '0;
        fgMem[i] <= '0;
      end else begin
        if (cmd.bgWrite && (wrAddr == AW'(i))) bgMem[i] <= wrData;
        if (cmd.copyToFg) fgMem[i] <= bgMem[i];
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (rdAddr == AW'(i)) rdData = fgMem[i];
    end
  end
endmodule

// File: rtl/canRxCtl.sv
module canRxCtl
  import canRxPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxWrEn,
  input  logic    rxDone,
  input  logic    rxAccept,
  input  logic    rxOwn,
  input  logic    loopBack,
  input  logic    rxIntEn,
  input  logic    cpuClrFull,
  input  logic    cpuClrOvr,
  output bufCmd_t cmd,
  output logic    rxFull,
  output logic    rxOvr,
  output logic    rxIrq,
  output logic    bgPending
);
  logic qualified;
  logic directCopy;
  logic pendingMove;

  assign qualified   = rxDone && rxAccept && (!rxOwn || loopBack);
  assign directCopy  = qualified && !bgPending && !rxFull;
  assign pendingMove = bgPending && !rxFull;

  assign cmd.bgWrite  = rxWrEn && !bgPending;
  assign cmd.copyToFg = directCopy || pendingMove;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFull    <= 1'b0;
      rxOvr     <= 1'b0;
      bgPending <= 1'b0;
    end else begin
      if (cmd.copyToFg)       rxFull <= 1'b1;
      else if (cpuClrFull)    rxFull <= 1'b0;

      if (pendingMove)                              bgPending <= 1'b0;
      else if (qualified && !bgPending && rxFull)   bgPending <= 1'b1;

      if (qualified && bgPending) rxOvr <= 1'b1;
      else if (cpuClrOvr)         rxOvr <= 1'b0;
    end
  end

  assign rxIrq = rxFull && rxIntEn;
endmodule

// File: rtl/canRxStore.sv
module canRxStore
  import canRxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxWrEn,
  input  logic [ADDR_W-1:0] rxWrAddr,
  input  logic [BYTE_W-1:0] rxWrData,
  input  logic              rxDone,
  input  logic              rxAccept,
  input  logic              rxOwn,
  input  logic              loopBack,
  input  logic              rxIntEn,
  input  logic [ADDR_W-1:0] cpuRdAddr,
  output logic [BYTE_W-1:0] cpuRdData,
  input  logic              cpuClrFull,
  input  logic              cpuClrOvr,
  output logic              rxFull,
  output logic              rxOvr,
  output logic              rxIrq
);
  bufCmd_t cmd;
  logic    bgPending;

  canRxCtl u_ctl (
    .clk(clk), .rstN(rstN), .rxWrEn(rxWrEn), .rxDone(rxDone),
    .rxAccept(rxAccept), .rxOwn(rxOwn), .loopBack(loopBack),
    .rxIntEn(rxIntEn), .cpuClrFull(cpuClrFull), .cpuClrOvr(cpuClrOvr),
    .cmd(cmd), .rxFull(rxFull), .rxOvr(rxOvr), .rxIrq(rxIrq),
    .bgPending(bgPending)
  );

  canRxBufDp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrAddr(rxWrAddr),
    .wrData(rxWrData), .rdAddr(cpuRdAddr), .rdData(cpuRdData)
  );
endmodule

// File: rtl/canRxStoreChk.sv
module canRxStoreChk (
  input logic clk,
  input logic rstN,
  input logic rxDone,
  input logic rxAccept,
  input logic rxOwn,
  input logic loopBack,
  input logic rxIntEn,
  input logic cpuClrFull,
  input logic cpuClrOvr,
  input logic rxFull,
  input logic rxOvr,
  input logic rxIrq,
  input logic bgPending
);
  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq == (rxFull && rxIntEn));

  p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !cpuClrFull) |=> rxFull);

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxOvr && !cpuClrOvr) |=> rxOvr);

  p_own_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxOwn && !loopBack && !rxFull && !bgPending) |=> !rxFull);

  p_pending_moves_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bgPending && !rxFull) |=> (rxFull && !bgPending));

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bgPending && rxDone && rxAccept && (!rxOwn || loopBack)) |=> rxOvr);

  p_direct_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxAccept && !rxOwn && !rxFull && !bgPending) |=> rxFull);
endmodule

bind canRxStore canRxStoreChk u_chk (.*);

// File: tb/sim_canRxStore.sv
module sim_canRxStore;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxWrEn = 1'b0;
  logic [3:0] rxWrAddr = '0;
  logic [7:0] rxWrData = '0;
  logic       rxDone = 1'b0, rxAccept = 1'b0, rxOwn = 1'b0, loopBack = 1'b0;
  logic       rxIntEn = 1'b0;
  logic [3:0] cpuRdAddr = '0;
  logic [7:0] cpuRdData;
  logic       cpuClrFull = 1'b0, cpuClrOvr = 1'b0;
  logic       rxFull, rxOvr, rxIrq;

  int vecs = 0;
  int errs = 0;
  bit doneFlag = 0;

  always #10 clk = ~clk;

  canRxStore u0 (.*);

  function automatic logic [7:0] pat(int seed, int idx);
    return 8'((seed * 37 + idx * 11 + 5) & 8'hff);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(int seed);
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      rxWrEn = 1'b1; rxWrAddr = 4'(i); rxWrData = pat(seed, i);
    end
    @(negedge clk);
    rxWrEn = 1'b0;
  endtask

  task automatic finishFrame(logic acc, logic own);
    @(negedge clk);
    rxDone = 1'b1; rxAccept = acc; rxOwn = own;
    @(negedge clk);
    rxDone = 1'b0; rxAccept = 1'b0; rxOwn = 1'b0;
  endtask

  task automatic pulseClrFull();
    @(negedge clk); cpuClrFull = 1'b1;
    @(negedge clk); cpuClrFull = 1'b0;
  endtask

  task automatic checkFg(string req, int seed);
    for (int i = 0; i < 13; i++) begin
      cpuRdAddr = 4'(i);
      #1;
      chk(req, cpuRdData, (seed < 0) ? 8'h00 : pat(seed, i));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int lastSeed;
    lastSeed = -1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", {5'b0, rxFull, rxOvr, rxIrq}, 8'h00);

    // Sweep verdict, own flag, loop-back, interrupt enable (R3 R4 R5 R6)
    for (int k = 0; k < 16; k++) begin
      logic a, o, lb, ie, cp;
      a = k[0]; o = k[1]; lb = k[2]; ie = k[3];
      cp = a && (!o || lb);
      loopBack = lb; rxIntEn = ie;
      sendFrame(k + 1);
      finishFrame(a, o);
      chk(cp ? "R3" : (a ? "R6" : "R5"), {7'b0, rxFull}, {7'b0, cp});
      chk("R4", {7'b0, rxIrq}, {7'b0, cp && ie});
      if (cp) lastSeed = k + 1;
      checkFg(cp ? "R3" : "R5", lastSeed);
      pulseClrFull();
      chk("R9", {7'b0, rxFull}, 8'h00);
    end
    loopBack = 1'b0; rxIntEn = 1'b1;

    // Out-of-range read addresses (R2)
    for (int a2 = 13; a2 < 16; a2++) begin
      cpuRdAddr = 4'(a2); #1;
      chk("R2", cpuRdData, 8'h00);
    end

    // Pending and overrun path (R7 R8 R10)
    sendFrame(50);
    finishFrame(1'b1, 1'b0);
    chk("R3", {7'b0, rxFull}, 8'h01);
    sendFrame(51);                     // R10: accepted while foreground held
    finishFrame(1'b1, 1'b0);
    chk("R7", {7'b0, rxFull}, 8'h01);
    checkFg("R7", 50);
    chk("R8", {7'b0, rxOvr}, 8'h00);
    sendFrame(52);                     // R8: writes must be ignored
    finishFrame(1'b1, 1'b0);
    chk("R8", {7'b0, rxOvr}, 8'h01);
    @(negedge clk); cpuClrFull = 1'b1;
    @(negedge clk); cpuClrFull = 1'b0;
    chk("R7", {7'b0, rxFull}, 8'h00);  // gap cycle after clear
    @(negedge clk);
    chk("R7", {7'b0, rxFull}, 8'h01);
    chk("R4", {7'b0, rxIrq}, 8'h01);
    checkFg("R10", 51);
    chk("R9", {7'b0, rxOvr}, 8'h01);
    @(negedge clk); cpuClrOvr = 1'b1;
    @(negedge clk); cpuClrOvr = 1'b0;
    chk("R9", {7'b0, rxOvr}, 8'h00);
    chk("R9", {7'b0, rxFull}, 8'h01);

    doneFlag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule